// File: doc/BRIEF.md
# Per-Hart Interrupt Claim Unit

This block holds a pending flag and a routing register for each interrupt source, and gives every hart a small control window. Interrupt sources raise their pending flags with single-cycle pulses. Each routing register names the hart that serves its source. A hart takes an interrupt by reading the claim register in its own window. That read returns the lowest-numbered pending source routed to that hart, and the same access clears the flag of the source it returns.

Every hart also has a level output. It is high while at least one pending source is routed to that hart. The register port accepts one access per cycle and answers on the next cycle. The answer carries read data and an error bit. The other register slots in a window accept accesses and do nothing, so software that touches them during setup does not fault. A threshold comparison, forced interrupts and a top-interrupt view are not part of this block.

Top module: `claim_unit`

## Requirements
- R1: After reset all pending flags are clear, all routing registers hold hart 0, and `rsp_valid`, `rsp_err` and `hart_irq` are 0.
- R2: The routing register of source k (1 to NUM_SRC) is at byte address 0x3004 + (k-1)*4. Its hart field occupies bits [31:18], 14 bits. A read returns the stored field in [31:18] with all lower bits 0. Every access is answered exactly one cycle after it is presented.
- R3: A pulse on `src_set[k-1]` makes source k pending from the next cycle. `hart_irq[h]` is 1 exactly when some pending source has a routing field equal to h, so changing a routing register moves a pending source to another hart.
- R4: A read of byte address 0x4000 + h*32 + 0x1C is the claim read of hart h. It returns the lowest-numbered pending source whose routing field equals h. The source number is in bits [25:16], and every other bit is 0, which includes the priority field [7:0].
- R5: A claim read clears the pending flag of the source it returns. When no pending source is routed to the hart, the read returns 0 and changes no flag.
- R6: When a claim read and a `src_set` pulse for the returned source fall in the same cycle, the clear wins and the source is not pending afterwards. Pulses for other sources in that cycle take effect as usual.
- R7: A write to a claim register is ignored. No pending flag changes, and the response carries no error.
- R8: Accesses at window offsets 0x0, 0x4, 0x8 and 0x18 carry no error, read as 0 and change no state.
- R9: Each of the following answers with `rsp_err` = 1 and read data 0, and changes no state: any other offset inside a window, a window for a hart at or above NUM_HART, a routing register past NUM_SRC, an address that is not word aligned, and any other address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | An access is presented this cycle |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | ADDR_W | Byte address of the access |
| req_wdata | input | 32 | Write data |
| src_set | input | NUM_SRC | One pulse per source. Bit k-1 marks source k pending |
| rsp_valid | output | 1 | Response for the access of the previous cycle |
| rsp_rdata | output | 32 | Read data, 0 for writes and errors |
| rsp_err | output | 1 | The previous access hit no register |
| hart_irq | output | NUM_HART | Per hart: a pending source is routed here |

## Verification
The bound checker checks these rules on every cycle: each response follows its access by exactly one cycle, an error response carries zero data, and a claim response has a zero priority and zero unused bits. It also checks that a returned source was pending before the read and is clear after it, that an empty claim happens only while the hart's level was low, that a claim write drops no flag, and that `hart_irq` stays low while nothing is pending. Only the bench's reference model can show that the returned source is the lowest-numbered match. The same holds for routing changes moving pending sources between harts, a same-cycle set losing to the clear, and every malformed address answering with an error. The bench covers these with directed sequences and then with a long run of mixed random accesses and source pulses.

// File: rtl/claim_pkg.sv
`timescale 1ns/1ps
package claim_pkg;

    localparam int ROUTE_BASE  = 'h3004;
    localparam int WIN_BASE    = 'h4000;
    localparam int WIN_BYTES   = 32;
    localparam int OFF_CLAIM   = 'h1C;
    localparam int HART_LSB    = 18;
    localparam int HART_FW     = 14;
    localparam int ID_W        = 10;

    typedef logic [HART_FW-1:0] hart_field_t;

    typedef enum logic [1:0] {
        ACC_ERR,
        ACC_ROUTE,
        ACC_NOP,
        ACC_CLAIM
    } acc_kind_e;

    // Word returned by a claim read: source number in [25:16], priority 0.
    function automatic logic [31:0] claim_word(input logic [ID_W-1:0] id);
        return {6'd0, id, 8'd0, 8'd0};
    endfunction

    // Word returned by a routing register read.
    function automatic logic [31:0] route_word(input hart_field_t h);
        return {h, {HART_LSB{1'b0}}};
    endfunction

    function automatic hart_field_t route_field(input logic [31:0] w);
        return w[31:HART_LSB];
    endfunction

endpackage

// File: rtl/claim_decode.sv
`timescale 1ns/1ps
module claim_decode
    import claim_pkg::*;
#(
    parameter int NUM_SRC  = 24,
    parameter int NUM_HART = 4,
    parameter int ADDR_W   = 16,
    parameter int SRC_W    = 5,
    parameter int HART_W   = 2
) (
    input  logic [ADDR_W-1:0] addr,
    output acc_kind_e         kind,
    output logic [SRC_W-1:0]  src_idx,
    output logic [HART_W-1:0] hart_idx
);
    localparam int ROUTE_END = ROUTE_BASE + 4 * NUM_SRC;
    localparam int WIN_END   = WIN_BASE + WIN_BYTES * NUM_HART;

    logic [31:0] a32;
    logic [31:0] route_off;
    logic [31:0] win_off;

    assign a32       = 32'(addr);
    assign route_off = a32 - 32'(ROUTE_BASE);
    assign win_off   = a32 - 32'(WIN_BASE);

    always_comb begin
        kind     = ACC_ERR;
        src_idx  = '0;
        hart_idx = '0;
        if (a32[1:0] != 2'b00) begin
            kind = ACC_ERR;
        end else if (a32 >= 32'(ROUTE_BASE) && a32 < 32'(ROUTE_END)) begin
            kind    = ACC_ROUTE;
            src_idx = SRC_W'(route_off >> 2);
        end else if (a32 >= 32'(WIN_BASE) && a32 < 32'(WIN_END)) begin
            hart_idx = HART_W'(win_off >> 5);
            case (a32[4:0])
                5'h00, 5'h04, 5'h08, 5'h18: kind = ACC_NOP;
                5'(OFF_CLAIM):               kind = ACC_CLAIM;
                default:                     kind = ACC_ERR;
            endcase
        end
    end

endmodule

// File: rtl/claim_route_regs.sv
`timescale 1ns/1ps
module claim_route_regs
    import claim_pkg::*;
#(
    parameter int NUM_SRC = 24,
    parameter int SRC_W   = 5
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr_en,
    input  logic [SRC_W-1:0]          wr_idx,
    input  hart_field_t               wr_hart,
    output hart_field_t [NUM_SRC-1:0] route
);
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_route
        always_ff @(posedge clk) begin
            if (rst) begin
                route[s] <= '0;
            end else if (wr_en && wr_idx == SRC_W'(s)) begin
                route[s] <= wr_hart;
            end
        end
    end

endmodule

// File: rtl/claim_pending.sv
`timescale 1ns/1ps
module claim_pending #(
    parameter int NUM_SRC = 24,
    parameter int SRC_W   = 5
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] set_i,
    input  logic               clr_en,
    input  logic [SRC_W-1:0]   clr_idx,
    output logic [NUM_SRC-1:0] pend
);
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst) begin
                pend[s] <= 1'b0;
            end else if (clr_en && clr_idx == SRC_W'(s)) begin
                pend[s] <= 1'b0;   // claim beats a same-cycle set
            end else if (set_i[s]) begin
                pend[s] <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/claim_scan.sv
`timescale 1ns/1ps
module claim_scan
    import claim_pkg::*;
#(
    parameter int NUM_SRC  = 24,
    parameter int NUM_HART = 4,
    parameter int SRC_W    = 5,
    parameter int HART_W   = 2
) (
    input  logic [NUM_SRC-1:0]        pend,
    input  hart_field_t [NUM_SRC-1:0] route,
    input  logic [HART_W-1:0]         sel_hart,
    output logic                      found,
    output logic [SRC_W-1:0]          found_idx,
    output logic [NUM_HART-1:0]       hart_irq
);
    logic [NUM_SRC-1:0] sel_mask;

    for (genvar h = 0; h < NUM_HART; h++) begin : g_hart
        logic [NUM_SRC-1:0] hit;
        for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
            assign hit[s] = pend[s] && (route[s] == HART_FW'(h));
        end
        assign hart_irq[h] = |hit;
    end

    always_comb begin
        for (int s = 0; s < NUM_SRC; s++) begin
            sel_mask[s] = pend[s] && (route[s] == HART_FW'(sel_hart));
        end
    end

    // Lowest index wins: walk downward so the last hit kept is the lowest.
    always_comb begin
        found     = 1'b0;
        found_idx = '0;
        for (int s = NUM_SRC - 1; s >= 0; s--) begin
            if (sel_mask[s]) begin
                found     = 1'b1;
                found_idx = SRC_W'(s);
            end
        end
    end

endmodule

// File: rtl/claim_unit.sv
`timescale 1ns/1ps
module claim_unit
    import claim_pkg::*;
#(
    parameter int NUM_SRC  = 24,
    parameter int NUM_HART = 4,
    parameter int ADDR_W   = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [31:0]         req_wdata,
    input  logic [NUM_SRC-1:0]  src_set,
    output logic                rsp_valid,
    output logic [31:0]         rsp_rdata,
    output logic                rsp_err,
    output logic [NUM_HART-1:0] hart_irq
);
    localparam int SRC_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
    localparam int HART_W = (NUM_HART > 1) ? $clog2(NUM_HART) : 1;

    acc_kind_e                 kind;
    logic [SRC_W-1:0]          dec_src;
    logic [HART_W-1:0]         dec_hart;
    hart_field_t [NUM_SRC-1:0] route;
    logic [NUM_SRC-1:0]        pend;
    logic                      found;
    logic [SRC_W-1:0]          found_idx;
    logic                      route_wr;
    logic                      claim_rd;
    logic [31:0]               rdata_next;

    claim_decode #(
        .NUM_SRC(NUM_SRC), .NUM_HART(NUM_HART), .ADDR_W(ADDR_W),
        .SRC_W(SRC_W), .HART_W(HART_W)
    ) u_decode (
        .addr(req_addr), .kind(kind), .src_idx(dec_src), .hart_idx(dec_hart)
    );

    assign route_wr = req_valid && req_write && (kind == ACC_ROUTE);
    assign claim_rd = req_valid && !req_write && (kind == ACC_CLAIM);

    claim_route_regs #(.NUM_SRC(NUM_SRC), .SRC_W(SRC_W)) u_route (
        .clk(clk), .rst(rst), .wr_en(route_wr), .wr_idx(dec_src),
        .wr_hart(route_field(req_wdata)), .route(route)
    );

    claim_pending #(.NUM_SRC(NUM_SRC), .SRC_W(SRC_W)) u_pend (
        .clk(clk), .rst(rst), .set_i(src_set),
        .clr_en(claim_rd && found), .clr_idx(found_idx), .pend(pend)
    );

    claim_scan #(
        .NUM_SRC(NUM_SRC), .NUM_HART(NUM_HART), .SRC_W(SRC_W), .HART_W(HART_W)
    ) u_scan (
        .pend(pend), .route(route), .sel_hart(dec_hart),
        .found(found), .found_idx(found_idx), .hart_irq(hart_irq)
    );

    always_comb begin
        rdata_next = '0;
        if (req_valid && !req_write) begin
            case (kind)
                ACC_ROUTE: rdata_next = route_word(route[dec_src]);
                ACC_CLAIM: rdata_next = found ? claim_word(ID_W'(found_idx) + ID_W'(1)) : '0;
                default:   rdata_next = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_err   <= req_valid && (kind == ACC_ERR);
            rsp_rdata <= rdata_next;
        end
    end

endmodule

// File: rtl/claim_unit_chk.sv
`timescale 1ns/1ps
module claim_unit_chk #(
    parameter int NUM_SRC  = 24,
    parameter int NUM_HART = 4,
    parameter int ADDR_W   = 16
) (
    input logic                clk,
    input logic                rst,
    input logic                req_valid,
    input logic                req_write,
    input logic [ADDR_W-1:0]   req_addr,
    input logic                rsp_valid,
    input logic [31:0]         rsp_rdata,
    input logic                rsp_err,
    input logic [NUM_HART-1:0] hart_irq,
    input logic [NUM_SRC-1:0]  pend_q
);
    localparam int W_LO = 'h4000;
    localparam int W_HI = 'h4000 + 32 * NUM_HART;

    logic               is_claim_addr;
    logic               was_claim_rd;
    logic               was_claim_wr;
    logic [31:0]        was_hart;
    logic [NUM_SRC-1:0] pend_d;
    logic [NUM_HART-1:0] irq_d;
    logic [9:0]         id;
    logic               id_ok;
    logic               id_pend_now;
    logic               id_pend_before;
    logic               irq_before;

    assign is_claim_addr = (32'(req_addr) >= 32'(W_LO)) && (32'(req_addr) < 32'(W_HI))
                           && (req_addr[4:0] == 5'h1C);

    always_ff @(posedge clk) begin
        if (rst) begin
            was_claim_rd <= 1'b0;
            was_claim_wr <= 1'b0;
            was_hart     <= '0;
            pend_d       <= '0;
            irq_d        <= '0;
        end else begin
            was_claim_rd <= req_valid && !req_write && is_claim_addr;
            was_claim_wr <= req_valid && req_write && is_claim_addr;
            was_hart     <= (32'(req_addr) - 32'(W_LO)) >> 5;
            pend_d       <= pend_q;
            irq_d        <= hart_irq;
        end
    end

    assign id    = rsp_rdata[25:16];
    assign id_ok = (id != 10'd0) && (32'(id) <= 32'(NUM_SRC));

    always_comb begin
        id_pend_now    = 1'b0;
        id_pend_before = 1'b0;
        irq_before     = 1'b0;
        for (int s = 0; s < NUM_SRC; s++) begin
            if (32'(id) == 32'(s + 1)) begin
                id_pend_now    = pend_q[s];
                id_pend_before = pend_d[s];
            end
        end
        for (int h = 0; h < NUM_HART; h++) begin
            if (was_hart == 32'(h)) irq_before = irq_d[h];
        end
    end

    p_rsp_follows_req_r2: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);
    p_no_rsp_without_req_r2: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);
    p_err_zero_data_r9: assert property (@(posedge clk) disable iff (rst)
        rsp_err |-> (rsp_valid && rsp_rdata == 32'd0));
    p_claim_fields_r4: assert property (@(posedge clk) disable iff (rst)
        was_claim_rd |-> (rsp_rdata[15:0] == 16'd0 && rsp_rdata[31:26] == 6'd0 && !rsp_err));
    p_claim_was_pending_r5: assert property (@(posedge clk) disable iff (rst)
        (was_claim_rd && id != 10'd0) |-> (id_ok && id_pend_before));
    p_claim_clears_r6: assert property (@(posedge clk) disable iff (rst)
        (was_claim_rd && id_ok) |-> !id_pend_now);
    p_empty_claim_r5: assert property (@(posedge clk) disable iff (rst)
        (was_claim_rd && id == 10'd0) |-> !irq_before);
    p_claim_write_keeps_r7: assert property (@(posedge clk) disable iff (rst)
        was_claim_wr |-> ((pend_d & ~pend_q) == '0 && !rsp_err));
    p_irq_needs_pend_r3: assert property (@(posedge clk) disable iff (rst)
        (pend_q == '0) |-> (hart_irq == '0));

endmodule

bind claim_unit claim_unit_chk #(
    .NUM_SRC(NUM_SRC), .NUM_HART(NUM_HART), .ADDR_W(ADDR_W)
) i_chk (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .rsp_err(rsp_err), .hart_irq(hart_irq), .pend_q(pend)
);

// File: tb/test_claim_unit.sv
`timescale 1ns/1ps
module test_claim_unit;
    localparam int NS = 24;
    localparam int NH = 4;
    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [31:0]   req_wdata = '0;
    logic [NS-1:0] src_set = '0;
    logic          rsp_valid;
    logic [31:0]   rsp_rdata;
    logic          rsp_err;
    logic [NH-1:0] hart_irq;

    always #10 clk = ~clk;   // 50 MHz

    claim_unit #(.NUM_SRC(NS), .NUM_HART(NH), .ADDR_W(AW)) i_claim_unit (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .src_set(src_set),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
        .hart_irq(hart_irq)
    );

    int checks = 0;
    int errors = 0;
    int m_tgt[NS];
    bit m_pend[NS];
    bit finished = 0;

    function automatic logic [NH-1:0] exp_irq();
        logic [NH-1:0] r = '0;
        for (int s = 0; s < NS; s++)
            if (m_pend[s] && m_tgt[s] < NH) r[m_tgt[s]] = 1'b1;
        return r;
    endfunction

    // One access per cycle; the model advances with the same edge.
    task automatic op(input bit v, input bit w, input int a, input logic [31:0] d,
                      input logic [NS-1:0] sets, input string tag);
        bit          e_err = 0;
        logic [31:0] e_data = '0;
        int          clr = -1;
        int          tw = -1;
        req_valid = v; req_write = w; req_addr = AW'(a); req_wdata = d; src_set = sets;
        if (v) begin
            if (a % 4 != 0) e_err = 1;
            else if (a >= 'h3004 && a < 'h3004 + 4 * NS) begin
                int k = (a - 'h3004) / 4;
                if (w) tw = k; else e_data = 32'(m_tgt[k]) << 18;
            end else if (a >= 'h4000 && a < 'h4000 + 32 * NH) begin
                int h = (a - 'h4000) / 32;
                int off = (a - 'h4000) % 32;
                if (off == 'h1C) begin
                    if (!w) begin
                        for (int s = 0; s < NS; s++)
                            if (clr < 0 && m_pend[s] && m_tgt[s] == h) clr = s;
                        if (clr >= 0) e_data = 32'(clr + 1) << 16;
                    end
                end else if (!(off == 0 || off == 4 || off == 8 || off == 'h18)) e_err = 1;
            end else e_err = 1;
        end
        if (clr >= 0) m_pend[clr] = 0;
        for (int s = 0; s < NS; s++) if (sets[s] && s != clr) m_pend[s] = 1;
        if (tw >= 0) m_tgt[tw] = int'(d[31:18]);
        @(negedge clk);
        req_valid = 0; req_write = 0; src_set = '0;
        checks++;
        if (rsp_valid !== v || rsp_err !== e_err || rsp_rdata !== e_data || hart_irq !== exp_irq()) begin
            errors++;
            $display("FAIL %s: got valid=%0b err=%0b data=%08h irq=%b exp valid=%0b err=%0b data=%08h irq=%b",
                     tag, rsp_valid, rsp_err, rsp_rdata, hart_irq, v, e_err, e_data, exp_irq());
        end
    endtask

    task automatic wr_route(input int src, input int h, input string tag);
        op(1, 1, 'h3004 + (src - 1) * 4, (32'(h) << 18) | 32'h0002_ABCD, '0, tag);
    endtask
    task automatic rd_route(input int src, input string tag);
        op(1, 0, 'h3004 + (src - 1) * 4, '0, '0, tag);
    endtask
    task automatic claim(input int h, input logic [NS-1:0] sets, input string tag);
        op(1, 0, 'h4000 + h * 32 + 'h1C, '0, sets, tag);
    endtask
    task automatic pulse(input logic [NS-1:0] sets, input string tag);
        op(0, 0, 0, '0, sets, tag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        checks++;
        if (rsp_valid !== 0 || rsp_err !== 0 || hart_irq !== '0) begin
            errors++;
            $display("FAIL R1: got valid=%0b err=%0b irq=%b exp 0 0 0", rsp_valid, rsp_err, hart_irq);
        end
        rd_route(1, "R1 route reset");
        claim(0, '0, "R1 empty claim after reset");

        wr_route(1, 2, "R2 write route");
        wr_route(2, 0, "R2 write route");
        wr_route(5, 0, "R2 write route");
        wr_route(24, 3, "R2 write route");
        wr_route(10, 1, "R2 write route");
        wr_route(7, 9, "R2 write route to absent hart");
        rd_route(1, "R2 read route");
        rd_route(24, "R2 read route");
        rd_route(7, "R2 read route");

        pulse(24'h80_0012, "R3 set 2 5 24");
        pulse(24'h00_0040, "R3 set 7 absent hart");
        pulse('0, "R3 idle levels");
        wr_route(5, 1, "R3 retarget pending source");
        wr_route(5, 0, "R3 retarget back");

        claim(0, '0, "R4 lowest is 2");
        claim(0, '0, "R4 next is 5");
        claim(0, '0, "R5 empty returns 0");

        pulse(24'h00_0001, "R3 set 1");
        claim(2, 24'h00_0201, "R6 clear beats set on 1, set 10 lands");
        pulse('0, "R6 levels after");

        op(1, 1, 'h4000 + 32 + 'h1C, 32'hFFFF_FFFF, '0, "R7 claim write ignored");
        claim(1, '0, "R7 pending 10 still claimable");

        for (int i = 0; i < 4; i++) begin
            int offs[4] = '{0, 4, 8, 'h18};
            op(1, 0, 'h4000 + 3 * 32 + offs[i], '0, '0, "R8 noop read");
            op(1, 1, 'h4000 + 3 * 32 + offs[i], 32'hFFFF_FFFF, '0, "R8 noop write");
        end

        op(1, 0, 'h400C, '0, '0, "R9 bad window offset");
        op(1, 0, 'h4010, '0, '0, "R9 bad window offset");
        op(1, 1, 'h4014, 32'h1, '0, "R9 bad window offset write");
        op(1, 0, 'h4000 + NH * 32 + 'h1C, '0, '0, "R9 window past last hart");
        op(1, 1, 'h3004 + NS * 4, 32'hFFFF_FFFF, '0, "R9 route past last source");
        op(1, 0, 'h3000, '0, '0, "R9 unused address");
        op(1, 0, 'h3006, '0, '0, "R9 unaligned");
        op(1, 0, 'h0000, '0, '0, "R9 other address");
        claim(3, '0, "R4 hart 3 gets 24");

        for (int n = 0; n < 400; n++) begin
            logic [NS-1:0] sets = '0;
            int kind = int'($urandom % 7);
            int src  = 1 + int'($urandom % NS);
            for (int s = 0; s < NS; s++) sets[s] = ($urandom % 8) == 0;
            case (kind)
                0: op(1, 1, 'h3004 + (src - 1) * 4, ($urandom % 6) << 18 | ($urandom & 32'h3FFFF), sets, "R2 random route write");
                1: op(1, 0, 'h3004 + (src - 1) * 4, '0, sets, "R2 random route read");
                2, 3: claim(int'($urandom % (NH + 1)), sets, "R4 random claim");
                4: op(1, int'($urandom % 2), 'h4000 + int'($urandom % NH) * 32 + int'($urandom % 8) * 4, $urandom, sets, "R8 random window");
                5: op(1, int'($urandom % 2), int'($urandom % 'h5000), $urandom, sets, "R9 random address");
                default: pulse(sets, "R3 random pulse");
            endcase
        end

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got hung run exp completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule